// File: doc/BRIEF.md
# Debug Communications Mailbox

This block is a two-way word mailbox between a processor and an external debugger. Each direction has its own data register and its own handshake flag. The processor side works like coprocessor register access. It can read a control word, write the outgoing (processor-to-debugger) register and read the incoming (debugger-to-processor) register. The debugger side is a plain parallel port that takes the place of a scan chain. It can collect the outgoing word, deposit an incoming word, read the control word and write the control word.

Each flag is raised by one agent and lowered by the other, so each side can poll before it acts. The outgoing flag (W) shows that a processor word is waiting for the debugger. The incoming flag (R) shows that a debugger word is waiting for the processor. A producer that writes while its flag is up is ignored. The control word is read-only with one exception: a debugger write to it lowers R, which serves as a recovery path.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset both flags are 0 and both data registers read as zero.
- R2: The control word is identical on both sides and has this layout:
  - bits 31..28 hold the version pattern 4'b0011;
  - bits 27..2 read as zero;
  - bit 1 is W;
  - bit 0 is R.
- R3: A processor write while W=0 does two things from the next cycle on: the word appears on `dbg_rdata_o`, and W reads 1.
- R4: A debugger collect (`dbg_rd_i`) makes W read 0 from the next cycle on, and the outgoing data is kept.
- R5: A processor write while W=1 is ignored. The outgoing data and both flags stay unchanged.
- R6: A debugger write while R=0 does two things from the next cycle on: the word appears on `cpu_rdata_o`, and R reads 1.
- R7: A processor read (`cpu_rd_i`) makes R read 0 from the next cycle on, and the incoming data is kept.
- R8: A debugger write while R=1 is ignored. The incoming data and both flags stay unchanged.
- R9: A debugger control-word write makes R read 0 in the next cycle. It leaves W and both data registers unchanged.
- R10: When a set event and a clear event reach the same flag in one cycle, the flag ends at 0. An accepted write still stores its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_i | input | 1 | Processor write strobe for the outgoing register |
| cpu_wdata_i | input | DATA_W | Processor write data |
| cpu_rd_i | input | 1 | Processor read strobe for the incoming register (lowers R) |
| cpu_rdata_o | output | DATA_W | Incoming register contents |
| cpu_ctrl_o | output | DATA_W | Control word as seen by the processor |
| dbg_rd_i | input | 1 | Debugger collect strobe for the outgoing register (lowers W) |
| dbg_rdata_o | output | DATA_W | Outgoing register contents |
| dbg_wr_i | input | 1 | Debugger write strobe for the incoming register |
| dbg_wdata_i | input | DATA_W | Debugger write data |
| dbg_ctrl_wr_i | input | 1 | Debugger write to the control word (lowers R) |
| dbg_ctrl_o | output | DATA_W | Control word as seen by the debugger |

## Verification
The bench builds the block with its defaults: a 32-bit word, a 4-bit version field and the version pattern 4'b0011. With these values the full control-word layout can be checked directly, including every reserved bit and the exact version position at the top of the word. The data patterns cover all-ones, alternating bits and distinct words per direction, so a crossed data path or a stuck bit in either register shows up at the opposite port.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    // One flag's events for a cycle
    typedef struct packed {
        logic set;
        logic clr;
    } flag_evt_t;
endpackage

// File: rtl/dcc_flag.sv
module dcc_flag
    import dcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  flag_evt_t evt_i,
    output logic      flag_o
);
    logic flag_d, flag_q;

    // Clear is applied last so it takes priority
    always_comb begin
        flag_d = flag_q;
        if (evt_i.set) flag_d = 1'b1;
        if (evt_i.clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/dcc_hold_reg.sv
module dcc_hold_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (load_i) data_d = din_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout_o = data_q;
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
    import dcc_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter int                VER_W   = 4,
    parameter logic [VER_W-1:0]  VERSION = 4'b0011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic              cpu_rd_i,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic [DATA_W-1:0] cpu_ctrl_o,
    input  logic              dbg_rd_i,
    output logic [DATA_W-1:0] dbg_rdata_o,
    input  logic              dbg_wr_i,
    input  logic [DATA_W-1:0] dbg_wdata_i,
    input  logic              dbg_ctrl_wr_i,
    output logic [DATA_W-1:0] dbg_ctrl_o
);
    localparam int VER_LSB = DATA_W - VER_W;

    logic      w_flag, r_flag;
    logic      out_load, in_load;
    flag_evt_t w_evt, r_evt;
    logic [DATA_W-1:0] ctrl_word;

    // Event decode: a producer is accepted only while its flag is low
    always_comb begin
        out_load  = cpu_wr_i & ~w_flag;
        in_load   = dbg_wr_i & ~r_flag;
        w_evt.set = out_load;
        w_evt.clr = dbg_rd_i;
        r_evt.set = in_load;
        r_evt.clr = cpu_rd_i | dbg_ctrl_wr_i;
    end

    dcc_flag u_w_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (w_evt),
        .flag_o (w_flag)
    );

    dcc_flag u_r_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (r_evt),
        .flag_o (r_flag)
    );

    dcc_hold_reg #(.W(DATA_W)) u_out_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (out_load),
        .din_i  (cpu_wdata_i),
        .dout_o (dbg_rdata_o)
    );

    dcc_hold_reg #(.W(DATA_W)) u_in_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (in_load),
        .din_i  (dbg_wdata_i),
        .dout_o (cpu_rdata_o)
    );

    // Control word: version on top, reserved zero, flags at bits 1 and 0
    always_comb begin
        ctrl_word = '0;
        ctrl_word[DATA_W-1:VER_LSB] = VERSION;
        ctrl_word[1] = w_flag;
        ctrl_word[0] = r_flag;
    end

    assign cpu_ctrl_o = ctrl_word;
    assign dbg_ctrl_o = ctrl_word;
endmodule

// File: rtl/dcc_mailbox_chk.sv
module dcc_mailbox_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr_i,
    input logic              cpu_rd_i,
    input logic [DATA_W-1:0] cpu_rdata_o,
    input logic              dbg_rd_i,
    input logic [DATA_W-1:0] dbg_rdata_o,
    input logic              dbg_wr_i,
    input logic              dbg_ctrl_wr_i,
    input logic [DATA_W-1:0] dbg_ctrl_o
);
    logic w_s, r_s;
    assign w_s = dbg_ctrl_o[1];
    assign r_s = dbg_ctrl_o[0];

    assert_w_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && !w_s && !dbg_rd_i) |=> w_s);

    assert_w_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rd_i |=> !w_s);

    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_i && w_s) |=> $stable(dbg_rdata_o));

    assert_r_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr_i && !r_s && !cpu_rd_i && !dbg_ctrl_wr_i) |=> r_s);

    assert_r_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_i |=> !r_s);

    assert_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr_i && r_s) |=> $stable(cpu_rdata_o));

    assert_ctrl_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_ctrl_wr_i && !cpu_wr_i && !dbg_rd_i) |=> (!r_s && $stable(w_s)));
endmodule

bind dcc_mailbox dcc_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_wr_i      (cpu_wr_i),
    .cpu_rd_i      (cpu_rd_i),
    .cpu_rdata_o   (cpu_rdata_o),
    .dbg_rd_i      (dbg_rd_i),
    .dbg_rdata_o   (dbg_rdata_o),
    .dbg_wr_i      (dbg_wr_i),
    .dbg_ctrl_wr_i (dbg_ctrl_wr_i),
    .dbg_ctrl_o    (dbg_ctrl_o)
);

// File: tb/test_dcc_mailbox.sv
module test_dcc_mailbox;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr_i = 1'b0, cpu_rd_i = 1'b0;
    logic [DW-1:0] cpu_wdata_i = '0;
    logic [DW-1:0] cpu_rdata_o, cpu_ctrl_o, dbg_rdata_o, dbg_ctrl_o;
    logic          dbg_rd_i = 1'b0, dbg_wr_i = 1'b0, dbg_ctrl_wr_i = 1'b0;
    logic [DW-1:0] dbg_wdata_i = '0;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    dcc_mailbox i_dcc_mailbox (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_i(cpu_wr_i), .cpu_wdata_i(cpu_wdata_i),
        .cpu_rd_i(cpu_rd_i), .cpu_rdata_o(cpu_rdata_o), .cpu_ctrl_o(cpu_ctrl_o),
        .dbg_rd_i(dbg_rd_i), .dbg_rdata_o(dbg_rdata_o),
        .dbg_wr_i(dbg_wr_i), .dbg_wdata_i(dbg_wdata_i),
        .dbg_ctrl_wr_i(dbg_ctrl_wr_i), .dbg_ctrl_o(dbg_ctrl_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ctrl(input logic w, input logic r);
        return {4'b0011, 26'd0, w, r};
    endfunction

    // Apply strobes for one cycle; returns at the following negedge
    task automatic cycle(input logic cw, input logic [DW-1:0] cd, input logic cr,
                         input logic dr, input logic dw, input logic [DW-1:0] dd,
                         input logic dc);
        cpu_wr_i = cw; cpu_wdata_i = cd; cpu_rd_i = cr;
        dbg_rd_i = dr; dbg_wr_i = dw; dbg_wdata_i = dd; dbg_ctrl_wr_i = dc;
        @(negedge clk);
        cpu_wr_i = 0; cpu_rd_i = 0; dbg_rd_i = 0; dbg_wr_i = 0; dbg_ctrl_wr_i = 0;
    endtask

    task automatic t_reset;
        check("R1 out data", dbg_rdata_o, '0);
        check("R1 in data", cpu_rdata_o, '0);
        check("R1 ctrl", cpu_ctrl_o, ctrl(0, 0));
        check("R2 ctrl both sides", dbg_ctrl_o, cpu_ctrl_o);
        check("R2 version", {28'd0, cpu_ctrl_o[31:28]}, 32'd3);
    endtask

    task automatic t_outgoing;
        cycle(1, 32'hFFFF_FFFF, 0, 0, 0, '0, 0);
        check("R3 out data", dbg_rdata_o, 32'hFFFF_FFFF);
        check("R3 W set", cpu_ctrl_o, ctrl(1, 0));
        cycle(1, 32'h1234_5678, 0, 0, 0, '0, 0);
        check("R5 data kept", dbg_rdata_o, 32'hFFFF_FFFF);
        check("R5 flags", dbg_ctrl_o, ctrl(1, 0));
        cycle(0, '0, 0, 1, 0, '0, 0);
        check("R4 W clear", dbg_ctrl_o, ctrl(0, 0));
        check("R4 data kept", dbg_rdata_o, 32'hFFFF_FFFF);
        cycle(1, 32'hA5A5_5A5A, 0, 0, 0, '0, 0);
        check("R3 second word", dbg_rdata_o, 32'hA5A5_5A5A);
        cycle(0, '0, 0, 1, 0, '0, 0);
    endtask

    task automatic t_incoming;
        cycle(0, '0, 0, 0, 1, 32'h5555_AAAA, 0);
        check("R6 in data", cpu_rdata_o, 32'h5555_AAAA);
        check("R6 R set", cpu_ctrl_o, ctrl(0, 1));
        cycle(0, '0, 0, 0, 1, 32'hDEAD_BEEF, 0);
        check("R8 data kept", cpu_rdata_o, 32'h5555_AAAA);
        check("R8 flags", cpu_ctrl_o, ctrl(0, 1));
        cycle(0, '0, 1, 0, 0, '0, 0);
        check("R7 R clear", cpu_ctrl_o, ctrl(0, 0));
        check("R7 data kept", cpu_rdata_o, 32'h5555_AAAA);
        check("R6 no cross", dbg_rdata_o, 32'hA5A5_5A5A);
    endtask

    task automatic t_ctrl_write;
        cycle(1, 32'h0BAD_F00D, 0, 0, 1, 32'hCAFE_0001, 0);
        check("R9 setup", cpu_ctrl_o, ctrl(1, 1));
        cycle(0, '0, 0, 0, 0, '0, 1);
        check("R9 R clear W kept", dbg_ctrl_o, ctrl(1, 0));
        check("R9 in data kept", cpu_rdata_o, 32'hCAFE_0001);
        check("R9 out data kept", dbg_rdata_o, 32'h0BAD_F00D);
        cycle(0, '0, 0, 1, 0, '0, 0);
    endtask

    task automatic t_collide;
        cycle(1, 32'h1111_2222, 0, 1, 1, 32'h3333_4444, 1);
        check("R10 both flags low", cpu_ctrl_o, ctrl(0, 0));
        check("R10 out stored", dbg_rdata_o, 32'h1111_2222);
        check("R10 in stored", cpu_rdata_o, 32'h3333_4444);
        cycle(0, '0, 0, 0, 1, 32'h7777_8888, 0);
        cycle(0, '0, 1, 0, 1, 32'h9999_0000, 0);
        check("R10 read vs blocked write", cpu_ctrl_o, ctrl(0, 0));
        check("R8 blocked data", cpu_rdata_o, 32'h7777_8888);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_outgoing();
        t_incoming();
        t_ctrl_write();
        t_collide();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule